// File: doc/BRIEF.md
# Frame-Aligned Multi-Channel DAC Feeder

This block drives a bank of DAC channels from a single shared sample queue. Software pushes 9-bit words into a 64-entry FIFO. Each word carries 8 bits of sample data and a frame-start bit. A 16-bit reloading down-counter sets the sample rate. On each of its ticks, a sequencer drains one frame from the queue and writes it to channels 0, 1, 2 and onward, one channel per clock. Each write lands in a per-channel hold register that drives the converter.

The frame-start bit is what keeps the channels in order. If a word is lost, the frame ends early at the next start-marked word. If stray unmarked words sit at the head when a frame begins, they are discarded. Either way, a single fault never shifts samples onto the wrong channel for more than one frame.

A level interrupt stays raised while the fill count is at or below a programmable mark. This lets loosely timed software refill the queue in batches. It does not need to answer an interrupt on every sample. Two sticky error bits record ticks that found the queue empty and pushes that found it full.

Top module: `dac_frame_seq`

## Requirements
- R1: `fill` reports the number of stored words (0 to 64). It rises by one for each accepted push and falls by one for each word the sequencer consumes.
- R2: While `run` is high, `tick` pulses for one cycle every `period`+1 cycles. While `run` is low, `tick` stays low and the counter reloads from `period`.
- R3: A tick that finds a start-marked word at the head produces write strobes on consecutive cycles. The first strobe comes two cycles after the tick, plus one cycle per discarded word. Strobe k carries `dac_ch`=k and `dac_data` equal to bits 7:0 of the k-th word. The frame stops after channel CHANNELS-1.
- R4: Bit 8 of a word is the frame-start mark. After channel 0 has been written, a start-marked word at the head ends the frame without being consumed, and it opens the next tick's frame. An empty queue mid-frame also ends the frame, and does not set `underrun`. Channels not written keep their values.
- R5: Unmarked words at the head when a frame begins are consumed and discarded, one per cycle, and are never written.
- R6: A tick that finds the queue empty sets the sticky `underrun` bit. It produces no strobe, and all channel outputs are unchanged.
- R7: A push while `fill` is 64 is dropped, leaves `fill` at 64 and sets the sticky `overflow` bit.
- R8: `low_irq` is high exactly while `fill` is less than or equal to `low_mark`.
- R9: A one-cycle `err_clear` pulse clears `underrun` and `overflow`. Without it, both bits stay set once they are set.
- R10: `dac_level` bits [8c+7:8c] hold the last value written to channel c. They change only in the cycle that shows the strobe for c.
- R11: After reset, `fill` is 0, the error bits and `dac_we` are 0, and every channel output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push one word this cycle |
| push_data | input | 9 | Bit 8 frame-start mark, bits 7:0 sample |
| run | input | 1 | Enables the sample-rate counter |
| period | input | 16 | Tick interval minus one, in cycles |
| low_mark | input | 7 | Fill threshold for `low_irq` |
| err_clear | input | 1 | Clears both sticky error bits |
| tick | output | 1 | Sample-rate pulse |
| dac_we | output | 1 | Channel write strobe |
| dac_ch | output | 2 | Channel index of the current strobe |
| dac_data | output | 8 | Sample carried by the current strobe |
| dac_level | output | 32 | Held value of every channel, channel c at bits [8c+7:8c] |
| fill | output | 7 | Stored word count |
| low_irq | output | 1 | Refill request level |
| underrun | output | 1 | Sticky: a tick found the queue empty |
| overflow | output | 1 | Sticky: a push found the queue full |

## Verification
The hardest case to reach from the ports is a queue whose frames are malformed. This covers a frame missing a word followed by a properly marked one, and a stray unmarked word left at the head just as a tick arrives.

The stimulus builds batches of frames with a random word removed or a random extra word appended. It loads them while the counter is stopped, then releases the counter with a random period. Every resulting tick is compared with a queue model in the bench, including the extra cycle each discarded word costs. A directed phase fills the queue to its limit, pushes once more and then drains it to an empty tick.

// File: rtl/dac_frame_seq.sv
module dac_frame_seq #(
  parameter int CHANNELS = 4,
  parameter int DEPTH    = 64,
  parameter int DW       = 8,
  parameter int TW       = 16,
  localparam int SW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  input  logic [DW:0]            push_data,
  input  logic                   run,
  input  logic [TW-1:0]          period,
  input  logic [CW-1:0]          low_mark,
  input  logic                   err_clear,
  output logic                   tick,
  output logic                   dac_we,
  output logic [SW-1:0]          dac_ch,
  output logic [DW-1:0]          dac_data,
  output logic [CHANNELS*DW-1:0] dac_level,
  output logic [CW-1:0]          fill,
  output logic                   low_irq,
  output logic                   underrun,
  output logic                   overflow
);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          busy;
  logic [SW-1:0] ch;
  logic [DW-1:0] level_q [CHANNELS];

  logic          empty, full, push_ok, start;
  logic          pop, wr, fin;
  logic [DW:0]   head;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push_valid & ~full;
  assign head    = mem[rp];
  assign tick    = run & (tcnt == '0);
  assign start   = tick & ~busy & ~empty;
  assign fill    = cnt;
  assign low_irq = (cnt <= low_mark);

  // frame walk: ch==0 means channel 0 not yet written
  always_comb begin
    pop = 1'b0;
    wr  = 1'b0;
    fin = 1'b0;
    if (busy) begin
      if (empty) begin
        fin = 1'b1;
      end else if (ch == '0) begin
        pop = 1'b1;
        if (head[DW]) begin
          wr = 1'b1;
          if (CHANNELS == 1) fin = 1'b1;
        end
      end else if (head[DW]) begin
        fin = 1'b1;
      end else begin
        pop = 1'b1;
        wr  = 1'b1;
        if (int'(ch) == CHANNELS - 1) fin = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop)     rp <= rp + AW'(1);
      cnt <= cnt + CW'(push_ok) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               tcnt <= '0;
    else if (!run)            tcnt <= period;
    else if (tcnt == '0)      tcnt <= period;
    else                      tcnt <= tcnt - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ch   <= '0;
    end else begin
      if (start)    busy <= 1'b1;
      else if (fin) busy <= 1'b0;
      if (start || fin) ch <= '0;
      else if (wr)      ch <= ch + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_we   <= 1'b0;
      dac_ch   <= '0;
      dac_data <= '0;
    end else begin
      dac_we <= wr;
      if (wr) begin
        dac_ch   <= ch;
        dac_data <= head[DW-1:0];
      end
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)                      level_q[c] <= '0;
      else if (wr && int'(ch) == c)    level_q[c] <= head[DW-1:0];
    end
    assign dac_level[c*DW +: DW] = level_q[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underrun <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (tick && empty)       underrun <= 1'b1;
      else if (err_clear)      underrun <= 1'b0;
      if (push_valid && full)  overflow <= 1'b1;
      else if (err_clear)      overflow <= 1'b0;
    end
  end

endmodule

// File: rtl/dac_frame_seq_chk.sv
module dac_frame_seq_chk #(
  parameter int CHANNELS = 4,
  parameter int DEPTH    = 64,
  parameter int DW       = 8,
  parameter int SW       = 2,
  parameter int CW       = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   push_valid,
  input logic                   run,
  input logic                   err_clear,
  input logic                   tick,
  input logic                   dac_we,
  input logic [SW-1:0]          dac_ch,
  input logic [DW-1:0]          dac_data,
  input logic [CHANNELS*DW-1:0] dac_level,
  input logic [CW-1:0]          fill,
  input logic                   underrun,
  input logic                   overflow
);

  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  p_strobe_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_we && dac_ch != '0) |-> ($past(dac_we) && dac_ch == $past(dac_ch) + SW'(1)));

  p_strobe_channel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_we |-> (int'(dac_ch) < CHANNELS));

  p_empty_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fill == '0) |=> underrun);

  p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fill == CW'(DEPTH)) |=> overflow);

  p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !err_clear) |=> overflow);

  p_sticky_unr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !err_clear) |=> underrun);

  p_hold_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_we |-> $stable(dac_level));

  p_level_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dac_we |-> (dac_level[dac_ch*DW +: DW] == dac_data));

endmodule

bind dac_frame_seq dac_frame_seq_chk #(
  .CHANNELS(CHANNELS), .DEPTH(DEPTH), .DW(DW), .SW(SW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .run(run),
  .err_clear(err_clear), .tick(tick), .dac_we(dac_we), .dac_ch(dac_ch),
  .dac_data(dac_data), .dac_level(dac_level), .fill(fill),
  .underrun(underrun), .overflow(overflow)
);

// File: tb/test_dac_frame_seq.sv
module test_dac_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n, push_valid, run, err_clear;
  logic [8:0]  push_data;
  logic [15:0] period;
  logic [6:0]  low_mark;
  logic        tick, dac_we, low_irq, underrun, overflow;
  logic [1:0]  dac_ch;
  logic [7:0]  dac_data;
  logic [31:0] dac_level;
  logic [6:0]  fill;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_frame_seq #(.CHANNELS(N), .DEPTH(DEPTH)) i_dac_frame_seq (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .run(run), .period(period), .low_mark(low_mark), .err_clear(err_clear),
    .tick(tick), .dac_we(dac_we), .dac_ch(dac_ch), .dac_data(dac_data),
    .dac_level(dac_level), .fill(fill), .low_irq(low_irq),
    .underrun(underrun), .overflow(overflow)
  );

  int total = 0, bad = 0, cyc = 0, last_tick = -1;
  bit finished = 0;
  logic [8:0] mq[$];
  int lat[N];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit f, input logic [7:0] d);
    push_valid = 1'b1;
    push_data  = {f, d};
    @(negedge clk);
    push_valid = 1'b0;
    if (mq.size() < DEPTH) mq.push_back({f, d});
  endtask

  task automatic push_frame(input bit lose, input bit stray);
    int li = 1 + int'($urandom % (N - 1));
    for (int c = 0; c < N; c++) begin
      if (lose && c == li) continue;
      push(c == 0, 8'($urandom));
    end
    if (stray) push(1'b0, 8'($urandom));
  endtask

  task automatic pulse_clear();
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk(underrun == 1'b0, "R9 underrun cleared", underrun, 0);
    chk(overflow == 1'b0, "R9 overflow cleared", overflow, 0);
  endtask

  task automatic do_tick();
    int w = 0, d = 0, nw = 0, seen = 0;
    bit was_empty;
    logic [7:0] ew[N];
    while (!tick) begin
      @(negedge clk);
      w++;
      if (w > 200) begin
        chk(1'b0, "R2 tick timeout", w, 0);
        return;
      end
    end
    if (last_tick >= 0)
      chk(cyc - last_tick == int'(period) + 1, "R2 tick interval", cyc - last_tick, int'(period) + 1);
    last_tick = cyc;
    was_empty = (mq.size() == 0);
    while (mq.size() > 0 && !mq[0][8]) begin
      void'(mq.pop_front());
      d++;
    end
    if (mq.size() > 0) begin
      ew[0] = mq.pop_front()[7:0];
      nw = 1;
      while (nw < N && mq.size() > 0 && !mq[0][8]) begin
        ew[nw] = mq.pop_front()[7:0];
        nw++;
      end
    end
    for (int k = 0; k < nw; k++) lat[k] = int'(ew[k]);
    for (int j = 1; j <= d + N + 3; j++) begin
      @(negedge clk);
      if (dac_we) begin
        if (seen < nw) begin
          chk(int'(dac_ch) == seen, "R3 channel order", int'(dac_ch), seen);
          chk(dac_data == ew[seen], "R3 sample data", int'(dac_data), int'(ew[seen]));
          chk(j == d + 2 + seen, "R5 strobe cycle", j, d + 2 + seen);
        end else begin
          chk(1'b0, "R4 extra strobe", seen + 1, nw);
        end
        seen++;
      end
    end
    chk(seen == nw, "R4 strobe count", seen, nw);
    chk(underrun == was_empty, "R6 underrun on empty tick", underrun, was_empty);
    for (int c = 0; c < N; c++)
      chk(int'(dac_level[c*8 +: 8]) == lat[c], "R10 channel hold", int'(dac_level[c*8 +: 8]), lat[c]);
    chk(int'(fill) == mq.size(), "R1 fill after frame", int'(fill), mq.size());
    chk(low_irq == (mq.size() <= int'(low_mark)), "R8 low level irq", low_irq, mq.size() <= int'(low_mark));
    if (was_empty) pulse_clear();
  endtask

  task automatic drain();
    run = 1'b1;
    last_tick = -1;
    while (mq.size() > 0) do_tick();
    do_tick();
    run = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; push_valid = 1'b0; push_data = '0; run = 1'b0;
    err_clear = 1'b0; period = 16'd20; low_mark = 7'd8;
    for (int c = 0; c < N; c++) lat[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(fill == 0, "R11 fill at reset", fill, 0);
    chk(dac_we == 0, "R11 no strobe at reset", dac_we, 0);
    chk(underrun == 0 && overflow == 0, "R11 error bits at reset", {underrun, overflow}, 0);
    chk(dac_level == 0, "R11 channels at reset", int'(dac_level), 0);
    chk(low_irq == 1, "R8 irq when empty", low_irq, 1);

    for (int f = 0; f < DEPTH / N; f++) push_frame(1'b0, 1'b0);
    chk(int'(fill) == DEPTH, "R1 fill at limit", int'(fill), DEPTH);
    chk(overflow == 0, "R7 no overflow before limit", overflow, 0);
    chk(low_irq == 0, "R8 irq low above mark", low_irq, 0);
    push(1'b1, 8'hAA);
    chk(overflow == 1, "R7 overflow set", overflow, 1);
    chk(int'(fill) == DEPTH, "R7 fill unchanged by dropped push", int'(fill), DEPTH);
    @(negedge clk);
    chk(overflow == 1, "R9 overflow sticky", overflow, 1);
    pulse_clear();
    drain();

    repeat (40) begin
      @(negedge clk);
      chk(tick == 0, "R2 no tick while stopped", tick, 0);
    end

    for (int r = 0; r < 15; r++) begin
      int nf = 1 + int'($urandom % 5);
      low_mark = 7'($urandom % 65);
      period = 16'(16 + $urandom % 25);
      for (int f = 0; f < nf; f++)
        push_frame(($urandom % 5) == 0, ($urandom % 5) == 0);
      chk(int'(fill) == mq.size(), "R1 fill after pushes", int'(fill), mq.size());
      chk(low_irq == (mq.size() <= int'(low_mark)), "R8 irq after pushes", low_irq, mq.size() <= int'(low_mark));
      drain();
      repeat (3) @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule